// File: doc/BRIEF.md
# Dual-Channel LCD Segment/Common Driver Core

This core converts serial display data from an LCD controller into per-pixel bias-level selections for forty output channels. It is organised as two channels of twenty bits. Each channel has a serial shift register that fills from one end, and a parallel latch that captures the register contents. Every latched bit is then combined with the frame-alternation input to choose one of six bias levels. The level is reported as a 3-bit code, and the analog switches outside the core use that code.

The controller's shift clock, line-latch clock, alternation signal, mode select, direction inputs and serial data all arrive asynchronously. A fast system clock samples them through two-flop synchronizers, and edges are detected on the synchronized clocks. Each channel can shift toward higher or lower output numbers. The serial input pin and the serial output pin swap with the direction, and an output-enable marks which pin is driving. A mode input turns channel 2 into a common driver. In that mode channel 2 shifts on the rising edge of the latch clock, latches on the rising edge of the shift clock, and uses a common-style level table.

Top module: `lcd_drive_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both shift registers and both latches to 0. With `altIn`=0 and `commonMode`=0, every channel 1 code then reads 4 and every channel 2 code reads 6. Both serial outputs read 0.
- R2: With its direction input at 0, a channel takes data from its left input and moves it toward higher output numbers. Its right output then drives the last stage (output 20 or 40) with right enable 1 and left enable 0. With direction 1, data enters at the right input and moves toward lower numbers, and the left output drives the stage of output 1 or 21 with left enable 1 and right enable 0.
- R3: Channel 1 shifts one position on each falling edge of `shiftClk` and on no other event.
- R4: On each falling edge of `lineClk`, channel 1 copies its shift register into its latch.
- R5: With `commonMode`=0, channel 2 shifts on falling `shiftClk` and latches on falling `lineClk`, exactly like channel 1.
- R6: With `commonMode`=1, channel 2 shifts on rising `lineClk` and latches on rising `shiftClk`. In this mode the falling edges no longer act on channel 2.
- R7: `levelCode` holds output channel k (1..40) at bits [3k-1:3k-3], and code n (1..6) names bias level Vn. For channel 1, with latched bit and alternation written as (bit, alt): (1,1) gives 1, (1,0) gives 2, (0,1) gives 3 and (0,0) gives 4, for either mode.
- R8: For channel 2 with `commonMode`=1: (1,1) gives 2, (1,0) gives 1, (0,1) gives 6 and (0,0) gives 5.
- R9: For channel 2 with `commonMode`=0: (1,1) gives 1, (1,0) gives 2, (0,1) gives 5 and (0,0) gives 6.
- R10: Codes change only through a latch edge, a change of `altIn` or a change of `commonMode`. Shifting alone leaves every code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| lineClk | input | 1 | Controller latch clock (shift clock of channel 2 in common mode) |
| shiftClk | input | 1 | Controller shift clock (latch clock of channel 2 in common mode) |
| altIn | input | 1 | Frame alternation signal |
| commonMode | input | 1 | 1 makes channel 2 a common driver |
| dir1 | input | 1 | Channel 1 shift direction |
| dir2 | input | 1 | Channel 2 shift direction |
| leftIn1 | input | 1 | Channel 1 left serial pin, input side |
| rightIn1 | input | 1 | Channel 1 right serial pin, input side |
| leftIn2 | input | 1 | Channel 2 left serial pin, input side |
| rightIn2 | input | 1 | Channel 2 right serial pin, input side |
| leftOut1 | output | 1 | Channel 1 left serial pin, output value |
| leftOe1 | output | 1 | Channel 1 left pin drive enable |
| rightOut1 | output | 1 | Channel 1 right serial pin, output value |
| rightOe1 | output | 1 | Channel 1 right pin drive enable |
| leftOut2 | output | 1 | Channel 2 left serial pin, output value |
| leftOe2 | output | 1 | Channel 2 left pin drive enable |
| rightOut2 | output | 1 | Channel 2 right serial pin, output value |
| rightOe2 | output | 1 | Channel 2 right pin drive enable |
| levelCode | output | 120 | Forty 3-bit bias-level codes |

## Verification
The bench targets these cases:
- A single marked bit is walked the full length of a register in both directions. A design with a swapped end or direction makes that bit appear at the wrong pin or after the wrong pulse count.
- The mode input is flipped between pulses. A design that kept channel 2 on falling edges, or that used the segment table in common mode, shows codes that disagree with the common-driver mapping after a rising-edge latch.
- The alternation input is toggled with no latch edge. This catches codes that track the shift register instead of the latch, or that ignore the alternation polarity.
- Random mixes of pulses, data and direction changes catch any edge that drives the wrong channel.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int LEVEL_W = 3;

  // Synchronized controller pins, bundled for one synchronizer instance.
  typedef struct packed {
    logic lineClk;
    logic shiftClk;
    logic alt;
    logic common;
    logic dir1;
    logic dir2;
    logic leftIn1;
    logic rightIn1;
    logic leftIn2;
    logic rightIn2;
  } pins_t;

  // Strobes and qualified levels handed from control to datapath.
  typedef struct packed {
    logic shift1;
    logic latch1;
    logic shift2;
    logic latch2;
    logic data1;
    logic data2;
    logic dir1;
    logic dir2;
    logic alt;
    logic common;
  } ctrl_t;

  // Bias level selected for one output given channel role, latched bit and alternation.
  function automatic logic [LEVEL_W-1:0] levelOf(input logic second, input logic common,
                                                 input logic on, input logic alt);
    logic [LEVEL_W-1:0] lv;
    if (on) begin
      if (second && common) lv = alt ? LEVEL_W'(2) : LEVEL_W'(1);
      else                  lv = alt ? LEVEL_W'(1) : LEVEL_W'(2);
    end else if (!second) begin
      lv = alt ? LEVEL_W'(3) : LEVEL_W'(4);
    end else if (common) begin
      lv = alt ? LEVEL_W'(6) : LEVEL_W'(5);
    end else begin
      lv = alt ? LEVEL_W'(5) : LEVEL_W'(6);
    end
    return lv;
  endfunction

endpackage

// File: rtl/lcd_drv_sync.sv
module lcd_drv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/lcd_drv_ctrl.sv
module lcd_drv_ctrl
  import lcd_drv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  pins_t rawPins,
  output ctrl_t ctl
);
  localparam int PIN_W = $bits(pins_t);

  logic [PIN_W-1:0] syncVec;
  pins_t            pins;
  logic             prevLine;
  logic             prevShift;
  logic             lineRise, lineFall, shiftRise, shiftFall;

  lcd_drv_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (rawPins),
    .syncOut (syncVec)
  );

  assign pins = pins_t'(syncVec);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLine  <= 1'b0;
      prevShift <= 1'b0;
    end else begin
      prevLine  <= pins.lineClk;
      prevShift <= pins.shiftClk;
    end
  end

  assign lineRise  =  pins.lineClk  & ~prevLine;
  assign lineFall  = ~pins.lineClk  &  prevLine;
  assign shiftRise =  pins.shiftClk & ~prevShift;
  assign shiftFall = ~pins.shiftClk &  prevShift;

  always_comb begin
    ctl.shift1 = shiftFall;
    ctl.latch1 = lineFall;
    ctl.shift2 = pins.common ? lineRise  : shiftFall;
    ctl.latch2 = pins.common ? shiftRise : lineFall;
    ctl.data1  = pins.dir1 ? pins.rightIn1 : pins.leftIn1;
    ctl.data2  = pins.dir2 ? pins.rightIn2 : pins.leftIn2;
    ctl.dir1   = pins.dir1;
    ctl.dir2   = pins.dir2;
    ctl.alt    = pins.alt;
    ctl.common = pins.common;
  end
endmodule

// File: rtl/lcd_drv_datapath.sv
module lcd_drv_datapath
  import lcd_drv_pkg::*;
#(
  parameter int CHAN_W = 20
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrl_t                         ctl,
  output logic [1:0][CHAN_W-1:0]        srAll,
  output logic [1:0][CHAN_W-1:0]        latAll,
  output logic [2*CHAN_W*LEVEL_W-1:0]   codes
);
  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic              doShift, doLatch, dIn, dir;
    logic [CHAN_W-1:0] sr, lat;

    if (c == 0) begin : g_first
      assign doShift = ctl.shift1;
      assign doLatch = ctl.latch1;
      assign dIn     = ctl.data1;
      assign dir     = ctl.dir1;
    end else begin : g_second
      assign doShift = ctl.shift2;
      assign doLatch = ctl.latch2;
      assign dIn     = ctl.data2;
      assign dir     = ctl.dir2;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sr <= '0;
      end else if (doShift) begin
        if (dir) sr <= {dIn, sr[CHAN_W-1:1]};
        else     sr <= {sr[CHAN_W-2:0], dIn};
      end
    end

    always_ff @(posedge clk) begin
      if (rst)          lat <= '0;
      else if (doLatch) lat <= sr;
    end

    assign srAll[c]  = sr;
    assign latAll[c] = lat;

    for (genvar i = 0; i < CHAN_W; i++) begin : g_out
      assign codes[(c*CHAN_W+i)*LEVEL_W +: LEVEL_W] =
        levelOf((c == 1), ctl.common, lat[i], ctl.alt);
    end
  end
endmodule

// File: rtl/lcd_drive_core.sv
module lcd_drive_core
  import lcd_drv_pkg::*;
#(
  parameter int CHAN_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lineClk,
  input  logic                        shiftClk,
  input  logic                        altIn,
  input  logic                        commonMode,
  input  logic                        dir1,
  input  logic                        dir2,
  input  logic                        leftIn1,
  input  logic                        rightIn1,
  input  logic                        leftIn2,
  input  logic                        rightIn2,
  output logic                        leftOut1,
  output logic                        leftOe1,
  output logic                        rightOut1,
  output logic                        rightOe1,
  output logic                        leftOut2,
  output logic                        leftOe2,
  output logic                        rightOut2,
  output logic                        rightOe2,
  output logic [2*CHAN_W*LEVEL_W-1:0] levelCode
);
  pins_t                  rawPins;
  ctrl_t                  ctl;
  logic [1:0][CHAN_W-1:0] srAll;
  logic [1:0][CHAN_W-1:0] latAll;
  logic [CHAN_W-1:0]      sr1Q, sr2Q, lat1Q, lat2Q;

  always_comb begin
    rawPins.lineClk  = lineClk;
    rawPins.shiftClk = shiftClk;
    rawPins.alt      = altIn;
    rawPins.common   = commonMode;
    rawPins.dir1     = dir1;
    rawPins.dir2     = dir2;
    rawPins.leftIn1  = leftIn1;
    rawPins.rightIn1 = rightIn1;
    rawPins.leftIn2  = leftIn2;
    rawPins.rightIn2 = rightIn2;
  end

  lcd_drv_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rawPins (rawPins),
    .ctl     (ctl)
  );

  lcd_drv_datapath #(.CHAN_W(CHAN_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .srAll  (srAll),
    .latAll (latAll),
    .codes  (levelCode)
  );

  assign sr1Q  = srAll[0];
  assign sr2Q  = srAll[1];
  assign lat1Q = latAll[0];
  assign lat2Q = latAll[1];

  // Both ends always present the end stage; the enable names the driving pin.
  assign leftOut1  = sr1Q[0];
  assign rightOut1 = sr1Q[CHAN_W-1];
  assign leftOe1   = ctl.dir1;
  assign rightOe1  = ~ctl.dir1;
  assign leftOut2  = sr2Q[0];
  assign rightOut2 = sr2Q[CHAN_W-1];
  assign leftOe2   = ctl.dir2;
  assign rightOe2  = ~ctl.dir2;
endmodule

// File: rtl/lcd_drive_chk.sv
module lcd_drive_chk
  import lcd_drv_pkg::*;
#(
  parameter int CHAN_W = 20
) (
  input logic                        clk,
  input logic                        rst,
  input ctrl_t                       ctl,
  input logic [CHAN_W-1:0]           sr1,
  input logic [CHAN_W-1:0]           sr2,
  input logic [CHAN_W-1:0]           lat1,
  input logic [CHAN_W-1:0]           lat2,
  input logic [2*CHAN_W*LEVEL_W-1:0] codes,
  input logic                        leftOe1,
  input logic                        rightOe1,
  input logic                        leftOe2,
  input logic                        rightOe2
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sr1 == '0) && (sr2 == '0) && (lat1 == '0) && (lat2 == '0));

  p_one_driver_r2: assert property (@(posedge clk) disable iff (rst)
    (leftOe1 != rightOe1) && (leftOe2 != rightOe2));

  p_sr1_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ctl.shift1 |=> $stable(sr1));

  p_lat1_copy_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.latch1 |=> (lat1 == $past(sr1)));

  p_sr2_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl.shift2 |=> $stable(sr2));

  p_lat2_copy_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.latch2 |=> (lat2 == $past(sr2)));

  p_lat1_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl.latch1 |=> $stable(lat1));

  p_codes_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ($stable(lat1) && $stable(lat2) && $stable(ctl.alt) && $stable(ctl.common))
      |-> $stable(codes));

  for (genvar i = 0; i < CHAN_W; i++) begin : g_range
    p_ch1_range_r7: assert property (@(posedge clk) disable iff (rst)
      (codes[i*LEVEL_W +: LEVEL_W] >= LEVEL_W'(1)) &&
      (codes[i*LEVEL_W +: LEVEL_W] <= LEVEL_W'(4)));
  end
endmodule

bind lcd_drive_core lcd_drive_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctl      (ctl),
  .sr1      (sr1Q),
  .sr2      (sr2Q),
  .lat1     (lat1Q),
  .lat2     (lat2Q),
  .codes    (levelCode),
  .leftOe1  (leftOe1),
  .rightOe1 (rightOe1),
  .leftOe2  (leftOe2),
  .rightOe2 (rightOe2)
);

// File: tb/tb_lcd_drive_core.sv
`timescale 1ns/1ps
module tb_lcd_drive_core;
  localparam int W  = 20;
  localparam int LW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic lineClk = 0, shiftClk = 0, altIn = 0, commonMode = 0;
  logic dir1 = 0, dir2 = 0, leftIn1 = 0, rightIn1 = 0, leftIn2 = 0, rightIn2 = 0;
  logic leftOut1, leftOe1, rightOut1, rightOe1, leftOut2, leftOe2, rightOut2, rightOe2;
  logic [2*W*LW-1:0] levelCode;

  lcd_drive_core #(.CHAN_W(W)) dut (
    .clk(clk), .rst(rst), .lineClk(lineClk), .shiftClk(shiftClk), .altIn(altIn),
    .commonMode(commonMode), .dir1(dir1), .dir2(dir2), .leftIn1(leftIn1),
    .rightIn1(rightIn1), .leftIn2(leftIn2), .rightIn2(rightIn2),
    .leftOut1(leftOut1), .leftOe1(leftOe1), .rightOut1(rightOut1), .rightOe1(rightOe1),
    .leftOut2(leftOut2), .leftOe2(leftOe2), .rightOut2(rightOut2), .rightOe2(rightOe2),
    .levelCode(levelCode)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [W-1:0] mSr1 = '0, mSr2 = '0, mLat1 = '0, mLat2 = '0;

  // Expected level from the requirement tables (R7, R8, R9).
  function automatic logic [LW-1:0] expLevel(int ch, logic common, logic on, logic alt);
    if (ch == 0) begin
      case ({on, alt}) 2'b11: return 3'd1; 2'b10: return 3'd2; 2'b01: return 3'd3; default: return 3'd4; endcase
    end else if (common) begin
      case ({on, alt}) 2'b11: return 3'd2; 2'b10: return 3'd1; 2'b01: return 3'd6; default: return 3'd5; endcase
    end else begin
      case ({on, alt}) 2'b11: return 3'd1; 2'b10: return 3'd2; 2'b01: return 3'd5; default: return 3'd6; endcase
    end
  endfunction

  function automatic logic [W-1:0] shifted(logic [W-1:0] s, logic d, logic dir);
    return dir ? {d, s[W-1:1]} : {s[W-2:0], d};
  endfunction

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkCodes(string req);
    logic [2*W*LW-1:0] e;
    for (int i = 0; i < W; i++) begin
      e[i*LW +: LW]     = expLevel(0, commonMode, mLat1[i], altIn);
      e[(W+i)*LW +: LW] = expLevel(1, commonMode, mLat2[i], altIn);
    end
    check(req, "levelCode", 128'(levelCode), 128'(e));
  endtask

  task automatic checkSerial(string req);
    check(req, "serial ch1", {124'd0, leftOut1, rightOut1, leftOe1, rightOe1},
          {124'd0, mSr1[0], mSr1[W-1], dir1, ~dir1});
    check(req, "serial ch2", {124'd0, leftOut2, rightOut2, leftOe2, rightOe2},
          {124'd0, mSr2[0], mSr2[W-1], dir2, ~dir2});
  endtask

  task automatic settle;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setLine(logic v);
    if (lineClk && !v) begin
      mLat1 = mSr1;
      if (!commonMode) mLat2 = mSr2;
    end
    if (!lineClk && v && commonMode) mSr2 = shifted(mSr2, dir2 ? rightIn2 : leftIn2, dir2);
    lineClk = v;
    settle();
  endtask

  task automatic setShift(logic v);
    if (shiftClk && !v) begin
      mSr1 = shifted(mSr1, dir1 ? rightIn1 : leftIn1, dir1);
      if (!commonMode) mSr2 = shifted(mSr2, dir2 ? rightIn2 : leftIn2, dir2);
    end
    if (!shiftClk && v && commonMode) mLat2 = mSr2;
    shiftClk = v;
    settle();
  endtask

  task automatic pulseLine;  setLine(1);  setLine(0);  endtask
  task automatic pulseShift; setShift(1); setShift(0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    checkCodes("R1");
    checkSerial("R1");

    // R2/R3: walk one marked bit through channel 1 toward output 20.
    leftIn1 = 1'b1;
    pulseShift();
    leftIn1 = 1'b0;
    checkSerial("R3");
    checkCodes("R10");
    for (int k = 0; k < W - 2; k++) pulseShift();
    checkSerial("R2");
    pulseShift();
    check("R2", "rightOut1 after 20 shifts", 128'(rightOut1), 128'(1));
    checkCodes("R10");

    pulseLine();
    checkCodes("R4");
    altIn = 1'b1;
    settle();
    checkCodes("R7");

    // R5/R9: channel 2 in segment mode, shifting toward output 21.
    dir2 = 1'b1;
    rightIn2 = 1'b1;
    pulseShift();
    pulseShift();
    rightIn2 = 1'b0;
    checkSerial("R5");
    pulseLine();
    checkCodes("R5");
    altIn = 1'b0;
    settle();
    checkCodes("R9");

    // R6/R8: common mode swaps edges and table.
    commonMode = 1'b1;
    settle();
    checkCodes("R8");
    rightIn2 = 1'b1;
    pulseLine();
    checkSerial("R6");
    checkCodes("R6");
    pulseShift();
    checkCodes("R6");
    altIn = 1'b1;
    settle();
    checkCodes("R8");

    // R2: reverse channel 1 direction.
    dir1 = 1'b1;
    rightIn1 = 1'b1;
    settle();
    checkSerial("R2");
    pulseShift();
    checkSerial("R2");

    // Random mix.
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 7)
        0: pulseLine();
        1: pulseShift();
        2: begin altIn = ~altIn; settle(); end
        3: begin {leftIn1, rightIn1, leftIn2, rightIn2} = 4'($urandom); settle(); end
        4: begin {dir1, dir2} = 2'($urandom); settle(); end
        5: if ($urandom % 3 == 0) begin commonMode = ~commonMode; settle(); end
        default: begin pulseShift(); pulseLine(); end
      endcase
      checkCodes("R7");
      checkSerial("R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule